// File: doc/BRIEF.md
# Segmented ROM Bank Address Mapper

The mapper turns a 20-bit processor address into a region choice and, for cartridge ROM, a 64 KB bank index plus a byte offset inside that bank. The top four address bits pick one of sixteen 64 KB segments. Segment 0 is internal RAM and segment 1 is cartridge static RAM. The remaining fourteen segments read ROM.

Three byte-wide registers steer the ROM banks, and the processor writes and reads them through a small I/O port. The register at I/O 0xC2 holds the complete bank number for segment 2, and the one at 0xC3 holds it for segment 3. For segments 4 to 15, the bank number is built from two parts. Its low nibble is the segment number itself, and its high nibble comes from bits 3:0 of the shared register at 0xC0.

Bank numbers count down from the top of ROM, so 0xFF always means the last 64 KB. A size mask then trims the bank number to the banks that are actually fitted. A smaller ROM therefore mirrors, and bank 0xFF still lands on its final bank. The address translation is purely combinational. Register writes take effect on the clock edge.

Top module: `rom_seg_mapper`

## Requirements
- R1: Exactly one of `sel_ram`, `sel_sram`, `sel_rom` is high for every address. Segment 0 gives `sel_ram`, segment 1 gives `sel_sram`, and segments 2 to 15 give `sel_rom`. `rom_bank` is 0 whenever `sel_rom` is low.
- R2: After reset, reading I/O 0xC0 returns 0x2F, and reading 0xC2 or 0xC3 returns 0xFF.
- R3: In segment 2, `rom_bank` equals the value of register 0xC2 ANDed with `BANK_MASK`.
- R4: In segment 3, `rom_bank` equals the value of register 0xC3 ANDed with `BANK_MASK`.
- R5: In segments 4 to 15, `rom_bank` is formed as follows, then ANDed with `BANK_MASK`. Bits 7:4 are bits 3:0 of register 0xC0. Bits 3:0 are the segment number. Bits 7:4 of register 0xC0 have no effect on the bank.
- R6: `rom_offset` equals address bits 15:0.
- R7: `rom_bank` never has a bit set outside `BANK_MASK`, which defaults to 0x3F (64 banks). A bank value of 0xFF therefore selects bank 0x3F.
- R8: Reading one of the three register addresses returns the full byte last written there. Reading any other I/O address returns 0.
- R9: A write to any I/O address other than 0xC0, 0xC2 and 0xC3 changes no register and no mapping output.
- R10: The outputs follow a change of `cpu_addr` in the same cycle, with no clock. A register write changes the mapping only after the clock edge that captures it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_we | input | 1 | Register write strobe |
| io_addr | input | 8 | I/O register address for both read and write |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data for `io_addr` |
| cpu_addr | input | 20 | Processor address to translate |
| sel_ram | output | 1 | Internal RAM region selected |
| sel_sram | output | 1 | Cartridge SRAM region selected |
| sel_rom | output | 1 | Cartridge ROM region selected |
| rom_bank | output | 8 | Masked ROM bank index |
| rom_offset | output | 16 | Byte offset within the bank |

## Verification
The hardest case to reach is the high nibble of register 0xC0. It must be shown to play no part in the bank, while the low nibble and the segment number are still joined in the right order. Masking hides most of this from the outputs. The bench therefore writes 0x4E and then 0xF4 to 0xC0 and reads ROM segments whose expected banks differ only in bits that survive the 0x3F mask. A foreign write just before a readback shows that the registers and outputs are left untouched.

// File: rtl/rom_seg_mapper.sv
module rom_seg_mapper #(
  parameter int          SEG_W      = 4,
  parameter int          OFS_W      = 16,
  parameter int          BANK_W     = 8,
  parameter int          IO_AW      = 8,
  parameter logic [7:0]  BANK_MASK  = 8'h3F,
  parameter logic [7:0]  HI_ADDR    = 8'hC0,
  parameter logic [7:0]  S2_ADDR    = 8'hC2,
  parameter logic [7:0]  S3_ADDR    = 8'hC3,
  parameter logic [7:0]  HI_RST     = 8'h2F,
  parameter logic [7:0]  S2_RST     = 8'hFF,
  parameter logic [7:0]  S3_RST     = 8'hFF
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     io_we,
  input  logic [IO_AW-1:0]         io_addr,
  input  logic [BANK_W-1:0]        io_wdata,
  output logic [BANK_W-1:0]        io_rdata,
  input  logic [SEG_W+OFS_W-1:0]   cpu_addr,
  output logic                     sel_ram,
  output logic                     sel_sram,
  output logic                     sel_rom,
  output logic [BANK_W-1:0]        rom_bank,
  output logic [OFS_W-1:0]         rom_offset
);
  localparam int HALF = BANK_W / 2;

  logic [BANK_W-1:0] hi_q, s2_q, s3_q, raw_bank;
  logic [SEG_W-1:0]  seg;

  wire hit_hi = io_addr == IO_AW'(HI_ADDR);
  wire hit_s2 = io_addr == IO_AW'(S2_ADDR);
  wire hit_s3 = io_addr == IO_AW'(S3_ADDR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q <= BANK_W'(HI_RST);
      s2_q <= BANK_W'(S2_RST);
      s3_q <= BANK_W'(S3_RST);
    end else if (io_we) begin
      if (hit_hi) hi_q <= io_wdata;
      if (hit_s2) s2_q <= io_wdata;
      if (hit_s3) s3_q <= io_wdata;
    end
  end

  assign io_rdata = hit_hi ? hi_q : hit_s2 ? s2_q : hit_s3 ? s3_q : '0;

  assign seg        = cpu_addr[SEG_W+OFS_W-1:OFS_W];
  assign rom_offset = cpu_addr[OFS_W-1:0];
  assign sel_ram    = seg == SEG_W'(0);
  assign sel_sram   = seg == SEG_W'(1);
  assign sel_rom    = !sel_ram && !sel_sram;

  always_comb begin
    case (seg)
      SEG_W'(2): raw_bank = s2_q;
      SEG_W'(3): raw_bank = s3_q;
      default:   raw_bank = {hi_q[HALF-1:0], seg[HALF-1:0]};
    endcase
  end

  assign rom_bank = sel_rom ? (raw_bank & BANK_W'(BANK_MASK)) : '0;

  assert_one_region_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({sel_ram, sel_sram, sel_rom}));

  assert_bank_in_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_bank & ~BANK_W'(BANK_MASK)) == '0);

  assert_seg2_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (seg == SEG_W'(2) && $past(seg) == SEG_W'(2) && $past(rst_n) &&
     !$past(io_we && hit_s2)) |-> $stable(rom_bank));

  assert_readback_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (io_we && hit_s3) |=> (!hit_s3 || io_rdata == $past(io_wdata)));

  assert_foreign_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (io_we && !hit_hi && !hit_s2 && !hit_s3) |=>
      ($stable(hi_q) && $stable(s2_q) && $stable(s3_q)));
endmodule

// File: tb/sim_rom_seg_mapper.sv
module sim_rom_seg_mapper;
  logic        clk = 0, rst_n = 0, io_we = 0;
  logic [7:0]  io_addr = 0, io_wdata = 0, io_rdata;
  logic [19:0] cpu_addr = 0;
  logic        sel_ram, sel_sram, sel_rom;
  logic [7:0]  rom_bank;
  logic [15:0] rom_offset;
  int checks = 0, failures = 0, cycles = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rom_seg_mapper u0 (.clk, .rst_n, .io_we, .io_addr, .io_wdata, .io_rdata,
    .cpu_addr, .sel_ram, .sel_sram, .sel_rom, .rom_bank, .rom_offset);

  // {address, expected {ram,sram,rom}, expected bank} at reset register values
  localparam logic [30:0] VEC [10] = '{
    {20'h00123, 3'b100, 8'h00}, {20'h1ABCD, 3'b010, 8'h00},
    {20'h2F00F, 3'b001, 8'h3F}, {20'h30001, 3'b001, 8'h3F},
    {20'h4FFFF, 3'b001, 8'h34}, {20'h91234, 3'b001, 8'h39},
    {20'hA0000, 3'b001, 8'h3A}, {20'hF8000, 3'b001, 8'h3F},
    {20'h0FFFF, 3'b100, 8'h00}, {20'h10000, 3'b010, 8'h00}};

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk); io_we = 1; io_addr = a; io_wdata = d;
    @(negedge clk); io_we = 0;
  endtask

  task automatic rd(string req, logic [7:0] a, logic [7:0] exp);
    @(negedge clk); io_addr = a; #1; chk(req, io_rdata, exp);
  endtask

  task automatic map(string req, logic [19:0] a, logic [2:0] s, logic [7:0] b);
    cpu_addr = a; #1;
    chk(req, {sel_ram, sel_sram, sel_rom}, s);
    chk(req, rom_bank, b);
    chk("R6", rom_offset, a[15:0]);
  endtask

  task automatic finish_up;
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected<20000", cycles);
      finish_up();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd("R2", 8'hC0, 8'h2F);
    rd("R2", 8'hC2, 8'hFF);
    rd("R2", 8'hC3, 8'hFF);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      map("R1 R3 R4 R5 R7", VEC[i][30:11], VEC[i][10:8], VEC[i][7:0]);
    end
    wr(8'hC0, 8'h4E);
    map("R5", 20'h94444, 3'b001, 8'h29);
    rd("R8", 8'hC0, 8'h4E);
    wr(8'hC0, 8'hF4);
    map("R5 upper nibble ignored", 20'h50000, 3'b001, 8'h05);
    map("R5", 20'hB0000, 3'b001, 8'h0B);
    rd("R8", 8'hC0, 8'hF4);
    wr(8'hC2, 8'h10);
    map("R3", 20'h20000, 3'b001, 8'h10);
    wr(8'hC3, 8'hC7);
    map("R4", 20'h3ABCD, 3'b001, 8'h07);
    wr(8'hC1, 8'h00);
    wr(8'hC4, 8'h00);
    map("R9", 20'h20000, 3'b001, 8'h10);
    map("R9", 20'h3ABCD, 3'b001, 8'h07);
    map("R9", 20'h50000, 3'b001, 8'h05);
    rd("R9", 8'hC2, 8'h10);
    rd("R8", 8'hC1, 8'h00);
    rd("R8", 8'hC3, 8'hC7);
    // R10: write pending before the edge, visible after it
    @(negedge clk); cpu_addr = 20'h20000; io_we = 1; io_addr = 8'hC2; io_wdata = 8'hAB;
    #1; chk("R10 before edge", rom_bank, 8'h10);
    @(negedge clk); io_we = 0; #1;
    chk("R10 after edge", rom_bank, 8'h2B);
    cpu_addr = 20'h60000; #1; chk("R10 combinational", rom_bank, 8'h06);
    // R2: reset restores registers
    @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1;
    rd("R2", 8'hC2, 8'hFF);
    map("R2 R7", 20'h2FFFF, 3'b001, 8'h3F);
    finish_up();
  end
endmodule